// File: doc/BRIEF.md
# Dual-issue in-order instruction queue

This block is a small instruction holding queue that sits between a pre-decode buffer and an issue stage. On each clock it can take in zero, one or two instructions and let go of zero, one or two instructions. Its entries are always packed toward slot 0, with no holes between them. Slot 0 holds the oldest instruction.

Only the two lowest slots are issue candidates. Each candidate has its own ready input, driven by downstream pipeline availability. The upper candidate may leave while the lower one stalls. When that happens, the survivors close ranks so that no gap remains.

New instructions go into the lowest slots that are free once this cycle's departures are taken into account, behind everything that stays. The payload is an opaque data word with a small class tag. A synchronous flush empties the queue.

Top module: `dual_issue_queue`

## Requirements
- R1: After reset the queue is empty. Both candidate valid outputs are low and the free-slot output reads 2.
- R2: The free-slot output equals the smaller of 2 and (DEPTH minus the number of held entries at the start of the cycle). The producer offers no more instructions than this value.
- R3: Up to two instructions are accepted per clock. Input bit 0 marks the older word (data0/cls0) and bit 1 the younger word (data1/cls1). Bit 1 is only set together with bit 0.
- R4: Accepted instructions are placed behind every entry that remains after this cycle's departures. The older input word goes first, and program order among held entries is kept.
- R5: A candidate leaves in a cycle where its valid output and its ready input are both high. Both candidates may leave in the same cycle.
- R6: When slot 1 leaves and slot 0 stays, slot 0 keeps its entry and every entry above slot 1 moves down one place.
- R7: When slot 0 leaves and slot 1 stays, every remaining entry moves down one place in that cycle.
- R8: A flush leaves the queue empty on the next cycle and overrides any accept or issue in the same cycle.
- R9: A valid slot-0 entry whose ready is low stays in slot 0 unchanged on the next cycle, unless a flush occurs.
- R10: The occupancy never exceeds DEPTH. Candidate 1 is valid only when candidate 0 is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Synchronous flush of all slots |
| in_valid_i | input | 2 | Offered instructions: bit 0 is the older, bit 1 the younger |
| in_data0_i | input | DATA_W | Payload of the older offered instruction |
| in_cls0_i | input | CLS_W | Class tag of the older offered instruction |
| in_data1_i | input | DATA_W | Payload of the younger offered instruction |
| in_cls1_i | input | CLS_W | Class tag of the younger offered instruction |
| free_o | output | 2 | Number of instructions that may be offered this cycle |
| c0_valid_o | output | 1 | Slot 0 holds an instruction |
| c0_data_o | output | DATA_W | Slot 0 payload |
| c0_cls_o | output | CLS_W | Slot 0 class tag |
| c0_ready_i | input | 1 | Downstream can take slot 0 |
| c1_valid_o | output | 1 | Slot 1 holds an instruction |
| c1_data_o | output | DATA_W | Slot 1 payload |
| c1_cls_o | output | CLS_W | Slot 1 class tag |
| c1_ready_i | input | 1 | Downstream can take slot 1 |

## Verification
The hard case is an out-of-order departure from slot 1 in the same cycle as two new arrivals. The arrivals must land directly behind the stalled slot-0 entry and behind the entries that shifted down.

The random stimulus produces this case: ready bits are drawn independently each cycle while the producer offers as many instructions as the free-slot count allows. A bench model applies the same departures and arrivals to an ordered list. The bench then compares both candidates with the model's first two entries on every cycle, so a misplaced arrival or a lost survivor shows up as a payload mismatch.

// File: rtl/dq_pkg.sv
package dq_pkg;
   typedef enum logic [1:0] {
      ISS_NONE = 2'd0,
      ISS_LOW  = 2'd1,
      ISS_HIGH = 2'd2,
      ISS_BOTH = 2'd3
   } iss_pat_e;

   localparam int unsigned PORTS = 2;
endpackage

// File: rtl/dq_ctrl.sv
module dq_ctrl #(
   parameter int unsigned DEPTH = 4,
   localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush_i,
   input  logic [1:0]    in_valid_i,
   input  logic          rdy0_i,
   input  logic          rdy1_i,
   input  logic [CW-1:0] cnt_i,
   output logic          iss0_o,
   output logic          iss1_o,
   output logic [1:0]    n_iss_o,
   output logic [1:0]    n_in_o,
   output logic [1:0]    free_o,
   output logic [CW-1:0] cnt_nxt_o,
   output dq_pkg::iss_pat_e pat_o
);
   localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

   logic [CW-1:0] room;

   always_comb begin
      room      = DEPTH_C - cnt_i;
      free_o    = (room >= CW'(2)) ? 2'd2 : room[1:0];
      iss0_o    = rdy0_i && (cnt_i >= CW'(1));
      iss1_o    = rdy1_i && (cnt_i >= CW'(2));
      n_iss_o   = {1'b0, iss0_o} + {1'b0, iss1_o};
      n_in_o    = {1'b0, in_valid_i[0]} + {1'b0, in_valid_i[0] & in_valid_i[1]};
      pat_o     = dq_pkg::iss_pat_e'({iss1_o, iss0_o});
      if (flush_i) cnt_nxt_o = '0;
      else         cnt_nxt_o = cnt_i - CW'(n_iss_o) + CW'(n_in_o);
   end

   p_credit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !flush_i |-> (n_in_o <= free_o));

   p_in_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid_i[1] |-> in_valid_i[0]);

   p_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> (cnt_i == '0));

   p_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_i <= DEPTH_C);
endmodule

// File: rtl/dq_slot_sel.sv
module dq_slot_sel #(
   parameter int unsigned K     = 0,
   parameter int unsigned DEPTH = 4,
   parameter int unsigned W     = 8,
   localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
   input  logic [W-1:0]  held_i [DEPTH],
   input  logic [CW-1:0] cnt_i,
   input  logic          iss0_i,
   input  logic [1:0]    n_iss_i,
   input  logic [1:0]    n_in_i,
   input  logic [W-1:0]  w0_i,
   input  logic [W-1:0]  w1_i,
   output logic [W-1:0]  nxt_o
);
   always_comb begin
      int rem;
      int src;
      int j;
      rem   = int'(cnt_i) - int'(n_iss_i);
      src   = (K == 0 && !iss0_i) ? 0 : int'(K) + int'(n_iss_i);
      j     = int'(K) - rem;
      nxt_o = held_i[K];
      if (int'(K) < rem) begin
         if (src < int'(DEPTH)) nxt_o = held_i[src];
      end else if (j == 0 && n_in_i >= 2'd1) begin
         nxt_o = w0_i;
      end else if (j == 1 && n_in_i >= 2'd2) begin
         nxt_o = w1_i;
      end
   end
endmodule

// File: rtl/dual_issue_queue.sv
module dual_issue_queue #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CLS_W  = 2,
   parameter int unsigned DEPTH  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush_i,
   input  logic [1:0]        in_valid_i,
   input  logic [DATA_W-1:0] in_data0_i,
   input  logic [CLS_W-1:0]  in_cls0_i,
   input  logic [DATA_W-1:0] in_data1_i,
   input  logic [CLS_W-1:0]  in_cls1_i,
   output logic [1:0]        free_o,
   output logic              c0_valid_o,
   output logic [DATA_W-1:0] c0_data_o,
   output logic [CLS_W-1:0]  c0_cls_o,
   input  logic              c0_ready_i,
   output logic              c1_valid_o,
   output logic [DATA_W-1:0] c1_data_o,
   output logic [CLS_W-1:0]  c1_cls_o,
   input  logic              c1_ready_i
);
   localparam int unsigned W  = DATA_W + CLS_W;
   localparam int unsigned CW = $clog2(DEPTH + 1);

   if (DEPTH < dq_pkg::PORTS) begin : g_bad_depth
      $error("dual_issue_queue: DEPTH must be at least 2");
   end
   if (DATA_W < 1 || CLS_W < 1) begin : g_bad_width
      $error("dual_issue_queue: widths must be positive");
   end

   logic [W-1:0]  ent_q   [DEPTH];
   logic [W-1:0]  ent_nxt [DEPTH];
   logic [CW-1:0] cnt_q, cnt_nxt;
   logic          iss0, iss1;
   logic [1:0]    n_iss, n_in;
   dq_pkg::iss_pat_e pat;

   dq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush_i   (flush_i),
      .in_valid_i(in_valid_i),
      .rdy0_i    (c0_ready_i),
      .rdy1_i    (c1_ready_i),
      .cnt_i     (cnt_q),
      .iss0_o    (iss0),
      .iss1_o    (iss1),
      .n_iss_o   (n_iss),
      .n_in_o    (n_in),
      .free_o    (free_o),
      .cnt_nxt_o (cnt_nxt),
      .pat_o     (pat)
   );

   for (genvar k = 0; k < DEPTH; k++) begin : g_slot
      dq_slot_sel #(.K(k), .DEPTH(DEPTH), .W(W)) u_sel (
         .held_i (ent_q),
         .cnt_i  (cnt_q),
         .iss0_i (iss0),
         .n_iss_i(n_iss),
         .n_in_i (n_in),
         .w0_i   ({in_cls0_i, in_data0_i}),
         .w1_i   ({in_cls1_i, in_data1_i}),
         .nxt_o  (ent_nxt[k])
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ent_q[k] <= '0;
         else        ent_q[k] <= ent_nxt[k];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_nxt;
   end

   assign c0_valid_o = (cnt_q >= CW'(1));
   assign c1_valid_o = (cnt_q >= CW'(2));
   assign {c0_cls_o, c0_data_o} = ent_q[0];
   assign {c1_cls_o, c1_data_o} = ent_q[1];

   p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (c0_valid_o && !c0_ready_i && !flush_i) |=> (ent_q[0] == $past(ent_q[0])));

   p_skip_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pat == dq_pkg::ISS_HIGH && cnt_q > CW'(2) && !flush_i)
      |=> (ent_q[1] == $past(ent_q[2])));

   p_shift_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pat == dq_pkg::ISS_LOW && cnt_q >= CW'(2) && !flush_i)
      |=> (ent_q[0] == $past(ent_q[1])));

   p_pair_r10: assert property (@(posedge clk) disable iff (!rst_n)
      c1_valid_o |-> c0_valid_o);
endmodule

// File: tb/dual_issue_queue_tb.sv
`timescale 1ns/1ps
module dual_issue_queue_tb;
   localparam int DEPTH = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush = 1'b0;
   logic [1:0]  in_valid = 2'b00;
   logic [31:0] d0 = '0, d1 = '0;
   logic [1:0]  k0 = '0, k1 = '0;
   logic [1:0]  free;
   logic        v0, v1, r0 = 1'b0, r1 = 1'b0;
   logic [31:0] q0, q1;
   logic [1:0]  qc0, qc1;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [31:0] md [DEPTH];
   logic [1:0]  mc [DEPTH];
   int          mcnt = 0;
   int unsigned seq = 1;
   string       tag = "R1";

   always #2.5 clk = ~clk;

   dual_issue_queue #(.DATA_W(32), .CLS_W(2), .DEPTH(DEPTH)) u_dut (
      .clk(clk), .rst_n(rst_n), .flush_i(flush), .in_valid_i(in_valid),
      .in_data0_i(d0), .in_cls0_i(k0), .in_data1_i(d1), .in_cls1_i(k1),
      .free_o(free),
      .c0_valid_o(v0), .c0_data_o(q0), .c0_cls_o(qc0), .c0_ready_i(r0),
      .c1_valid_o(v1), .c1_data_o(q1), .c1_cls_o(qc1), .c1_ready_i(r1)
   );

   function automatic int exp_free(int c);
      return (DEPTH - c >= 2) ? 2 : DEPTH - c;
   endfunction

   task automatic chk(string req, string what, longint act, longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic compare_all();
      chk("R2", "free", free, exp_free(mcnt));
      chk("R10", "c0_valid", v0, mcnt > 0);
      chk("R10", "c1_valid", v1, mcnt > 1);
      if (mcnt > 0) begin
         chk(tag, "c0_data", q0, md[0]);
         chk(tag, "c0_cls", qc0, mc[0]);
      end
      if (mcnt > 1) begin
         chk(tag, "c1_data", q1, md[1]);
         chk(tag, "c1_cls", qc1, mc[1]);
      end
   endtask

   // Drive one cycle at a negative edge and advance the model; compare at the next one.
   task automatic step(bit fl, bit rr0, bit rr1, int nreq);
      logic [31:0] nd [DEPTH];
      logic [1:0]  nc [DEPTH];
      int n = 0;
      bit i0, i1;
      int lim = exp_free(mcnt);
      if (nreq > lim) nreq = lim;
      flush = fl; r0 = rr0; r1 = rr1;
      in_valid = (nreq == 2) ? 2'b11 : (nreq == 1) ? 2'b01 : 2'b00;
      d0 = seq; k0 = 2'(seq ^ (seq >> 3));
      d1 = seq + 1; k1 = 2'((seq + 1) ^ ((seq + 1) >> 3));
      i0 = rr0 && mcnt > 0;
      i1 = rr1 && mcnt > 1;
      if (fl) tag = "R8";
      else if (i0 && i1) tag = "R5";
      else if (i1) tag = "R6";
      else if (i0) tag = "R7";
      else if (mcnt > 0) tag = "R9";
      else if (nreq == 2) tag = "R3";
      else tag = "R4";
      if (fl) begin
         mcnt = 0;
      end else begin
         for (int i = 0; i < mcnt; i++) begin
            if (!((i == 0 && i0) || (i == 1 && i1))) begin
               nd[n] = md[i]; nc[n] = mc[i]; n++;
            end
         end
         if (nreq >= 1) begin nd[n] = d0; nc[n] = k0; n++; end
         if (nreq >= 2) begin nd[n] = d1; nc[n] = k1; n++; end
         for (int i = 0; i < n; i++) begin md[i] = nd[i]; mc[i] = nc[i]; end
         mcnt = n;
      end
      seq += 2;
      @(negedge clk);
      compare_all();
   endtask

   initial begin
      process::self().srandom(32'd2024);
      repeat (3) @(negedge clk);
      // R1: state right after reset
      chk("R1", "free after reset", free, 2);
      chk("R1", "c0_valid after reset", v0, 0);
      chk("R1", "c1_valid after reset", v1, 0);
      rst_n = 1'b1;
      @(negedge clk);
      compare_all();
      // directed: fill, then slot-1-only issue with two arrivals pending
      step(0, 0, 0, 2);
      step(0, 0, 0, 2);
      chk("R2", "free when full", free, 0);
      step(0, 0, 1, 2);
      step(0, 1, 0, 1);
      step(0, 0, 0, 0);
      step(1, 1, 1, 2);
      step(0, 1, 1, 2);
      step(0, 1, 1, 2);
      // random mix
      for (int c = 0; c < 4000; c++) begin
         step(($urandom % 40) == 0, $urandom % 2, $urandom % 2, $urandom % 3);
      end
      step(0, 1, 1, 0);
      step(0, 1, 1, 0);
      chk("R1", "drained empty", v0, 0);
      flush = 0; in_valid = 0; r0 = 0; r1 = 0;
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule